// File: doc/BRIEF.md
# SPI Display Panel Power and Configuration Sequencer

This block brings a small LCD panel up and down on its own, with no help from software once a request is made. It owns the panel supply-enable line and an active-high panel reset line. It talks to the panel over a write-only serial link that sends 16-bit words. On a power-up request it turns the supply on, waits a settle time, releases reset and then sends the whole configuration script: timing mode, power control, two fixed bias registers, the mirror register and the 12-point gamma curve. On a power-down request it sends a two-stage standby script around a frame-length wait and then removes the supply.

A host issues one-cycle commands: power up, power down, set the vertical mirror flag, set the 3-bit timing mode or set one 10-bit gamma point. The block keeps shadow copies of mirror, mode and gamma. While the panel is powered, an update is also sent to the panel at once. While it is off, the update is only stored and is used at the next power-up. `busy` is high for as long as a script or a delay is running. Commands that arrive while it is high are dropped.

Top module: `panel_seq_top`

## Requirements
- R1: Every serial word is `{addr[5:0], 1'b0, 1'b1, data[7:0]}`. The register address is in bits 15:10, bit 9 is 0, bit 8 is 1 and the data byte is in bits 7:0.
- R2: The link runs in SPI mode 0 and sends MSB first. `spiSclk` idles low and `spiMosi` changes only while `spiSclk` is low. `spiCsN` stays low for exactly 16 rising clock edges per word and goes high between words.
- R3: Power-up sets `supplyEn`, waits at least `T_ON_CYC` cycles, drives `panelRst` low and then sends 20 words in this order: reg 0x02 = mode|0x08, reg 0x03 = 0xDF, reg 0x20 = 0xF0, reg 0x21 = 0xF0, reg 0x04, the three gamma high-bit registers, then the twelve gamma low-byte registers.
- R4: Reg 0x04 is sent as 0x17 when mirror is off and as 0x15 when mirror is on.
- R5: Gamma registers 0x11, 0x12 and 0x13 each hold bits 9:8 of four consecutive points, the first point of the group in bits 7:6 and the last in bits 1:0. Registers 0x14 to 0x1F hold bits 7:0 of points 0 to 11, sent in ascending order.
- R6: After reset, `supplyEn`=0, `panelRst`=1, `busy`=0, `spiCsN`=1 and `spiSclk`=0. The shadow mode is 7 and the gamma table is 105, 315, 381, 431, 490, 537, 579, 686, 780, 837, 880, 1023.
- R7: Power-down sends reg 0x03 = 0xD8, then drives `panelRst` high, waits at least `T_OFF_CYC` cycles, sends reg 0x03 = 0xD0 and then clears `supplyEn`.
- R8: A power-up request while powered, or a power-down request while off, is ignored: `busy` stays low and no word is sent.
- R9: A mode command whose 10-bit data exceeds 7 is rejected and changes nothing. A valid mode command, when powered, sends one reg 0x02 word with bit 3 set.
- R10: Mirror, mode and gamma commands issued while the panel is off send nothing. Their values appear in the next power-up script. A mirror command while powered sends one reg 0x04 word. A gamma command while powered sends the 15 gamma words.
- R11: Any command accepted while `busy` is high is dropped and changes no shadow value.
- R12: Command opcodes on `cmdOp`: 1 power up, 2 power down, 3 mirror (`cmdData[0]`), 4 mode (`cmdData`), 5 gamma point (`cmdIdx` 0..11, `cmdData`). Any other opcode, and a gamma index of 12 or more, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 3 | Command opcode |
| cmdIdx | input | 4 | Gamma point index |
| cmdData | input | 10 | Command value |
| busy | output | 1 | A script or delay is in progress |
| supplyEn | output | 1 | Panel supply enable |
| panelRst | output | 1 | Panel reset, active high |
| spiSclk | output | 1 | Serial clock |
| spiCsN | output | 1 | Serial chip select, active low |
| spiMosi | output | 1 | Serial data out |

## Verification
The in-line assertions check the cycle-level rules on every cycle: the clock idle level while deselected, data stability while the clock is high, the address/write-bit layout of every word handed to the serializer, reset released only with the supply on, the supply dropped only with reset asserted, and the shadow state frozen while busy. The word order, the data values, the gamma packing, the length of the settle delays, and whether a redundant or rejected command stays silent can only be shown by the bench. Its scoreboard decodes each word off the wire and compares it, together with the supply and reset levels at that moment, with a model built from the requirements.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int WORD_W = 16;
  localparam int GAMMA_N = 12;
  localparam int GAMMA_W = 10;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ON    = 3'd1,
    OP_OFF   = 3'd2,
    OP_MIRR  = 3'd3,
    OP_MODE  = 3'd4,
    OP_GAMMA = 3'd5
  } cmdOp_e;

  // strobes from control to the serializer
  typedef struct packed {
    logic              start;
    logic [WORD_W-1:0] word;
  } txStrobe_t;

  function automatic logic [WORD_W-1:0] mkWord(input logic [5:0] addr, input logic [7:0] data);
    return {addr, 1'b0, 1'b1, data};
  endfunction

  function automatic logic [GAMMA_W-1:0] defGamma(input int i);
    case (i)
      0:  return 10'd105;
      1:  return 10'd315;
      2:  return 10'd381;
      3:  return 10'd431;
      4:  return 10'd490;
      5:  return 10'd537;
      6:  return 10'd579;
      7:  return 10'd686;
      8:  return 10'd780;
      9:  return 10'd837;
      10: return 10'd880;
      default: return 10'd1023;
    endcase
  endfunction

endpackage

// File: rtl/panel_spi_tx.sv
module panel_spi_tx
  import panel_seq_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  output logic      txIdle,
  output logic      txDone,
  output logic      spiSclk,
  output logic      spiCsN,
  output logic      spiMosi
);

  localparam int HC_W  = $clog2(HALF_CYC + 1);
  localparam int BIT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {T_IDLE, T_LOW, T_HIGH, T_GAP} txState_e;

  txState_e          state;
  logic [WORD_W-1:0] shReg;
  logic [HC_W-1:0]   halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              halfEnd;

  assign halfEnd = (halfCnt == HC_W'(HALF_CYC - 1));
  assign txIdle  = (state == T_IDLE);
  assign spiMosi = shReg[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= T_IDLE;
      shReg   <= '0;
      halfCnt <= '0;
      bitCnt  <= '0;
      spiSclk <= 1'b0;
      spiCsN  <= 1'b1;
      txDone  <= 1'b0;
    end else begin
      txDone <= 1'b0;
      case (state)
        T_IDLE: if (strobe.start) begin
          shReg   <= strobe.word;
          spiCsN  <= 1'b0;
          halfCnt <= '0;
          bitCnt  <= '0;
          state   <= T_LOW;
        end
        T_LOW: begin
          halfCnt <= halfCnt + 1'b1;
          if (halfEnd) begin
            halfCnt <= '0;
            spiSclk <= 1'b1;
            state   <= T_HIGH;
          end
        end
        T_HIGH: begin
          halfCnt <= halfCnt + 1'b1;
          if (halfEnd) begin
            halfCnt <= '0;
            spiSclk <= 1'b0;
            if (bitCnt == BIT_W'(WORD_W - 1)) begin
              spiCsN <= 1'b1;
              state  <= T_GAP;
            end else begin
              shReg  <= {shReg[WORD_W-2:0], 1'b0};
              bitCnt <= bitCnt + 1'b1;
              state  <= T_LOW;
            end
          end
        end
        default: begin
          halfCnt <= halfCnt + 1'b1;
          if (halfEnd) begin
            halfCnt <= '0;
            txDone  <= 1'b1;
            state   <= T_IDLE;
          end
        end
      endcase
    end
  end

  // R2
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk);
  // R2
  mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> $stable(spiMosi));
  // R1
  word_format_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> (strobe.word[9:8] == 2'b01));
  // R2
  start_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> txIdle);

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int T_ON_CYC  = 20000000,
  parameter int T_OFF_CYC = 6250000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdOp,
  input  logic [3:0]   cmdIdx,
  input  logic [9:0]   cmdData,
  input  logic         txIdle,
  input  logic         txDone,
  output txStrobe_t    strobe,
  output logic         busy,
  output logic         supplyEn,
  output logic         panelRst
);

  localparam int DLY_MAX   = (T_ON_CYC > T_OFF_CYC) ? T_ON_CYC : T_OFF_CYC;
  localparam int DLY_W     = $clog2(DLY_MAX + 1);
  localparam int LIST_LAST = 19;
  localparam int MIRR_IDX  = 4;
  localparam int GHI_IDX   = 5;
  localparam int GLO_IDX   = 8;

  typedef enum logic [2:0] {S_IDLE, S_ONWAIT, S_ISSUE, S_WAITD, S_OFFWAIT} state_e;
  typedef enum logic [1:0] {P_LIST, P_OFF1, P_OFF2} phase_e;

  state_e             state;
  phase_e             phase;
  logic [DLY_W-1:0]   dlyCnt;
  logic [4:0]         idx, lastIdx;
  logic               powered;
  logic               mirrorReg;
  logic [2:0]         modeReg;
  logic [GAMMA_W-1:0] gammaReg [GAMMA_N];
  logic [WORD_W-1:0]  listWord;
  logic [4:0]         hiSel, loSel;
  logic [3:0]         base;

  assign busy = (state != S_IDLE);

  always_comb begin
    hiSel = idx - 5'(GHI_IDX);
    loSel = idx - 5'(GLO_IDX);
    base  = {hiSel[1:0], 2'b00};
    case (idx)
      5'd0: listWord = mkWord(6'h02, {5'b00001, modeReg});
      5'd1: listWord = mkWord(6'h03, 8'hDF);
      5'd2: listWord = mkWord(6'h20, 8'hF0);
      5'd3: listWord = mkWord(6'h21, 8'hF0);
      5'd4: listWord = mkWord(6'h04, mirrorReg ? 8'h15 : 8'h17);
      5'd5, 5'd6, 5'd7:
        listWord = mkWord(6'h11 + {4'b0, hiSel[1:0]},
                          {gammaReg[base][9:8], gammaReg[base + 4'd1][9:8],
                           gammaReg[base + 4'd2][9:8], gammaReg[base + 4'd3][9:8]});
      default: listWord = mkWord(6'h14 + {2'b0, loSel[3:0]}, gammaReg[loSel[3:0]][7:0]);
    endcase
    strobe.start = (state == S_ISSUE) && txIdle;
    case (phase)
      P_OFF1:  strobe.word = mkWord(6'h03, 8'hD8);
      P_OFF2:  strobe.word = mkWord(6'h03, 8'hD0);
      default: strobe.word = listWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phase     <= P_LIST;
      dlyCnt    <= '0;
      idx       <= '0;
      lastIdx   <= '0;
      powered   <= 1'b0;
      supplyEn  <= 1'b0;
      panelRst  <= 1'b1;
      mirrorReg <= 1'b0;
      modeReg   <= 3'd7;
      for (int i = 0; i < GAMMA_N; i++) gammaReg[i] <= defGamma(i);
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          phase <= P_LIST;
          case (cmdOp)
            OP_ON: if (!powered) begin
              supplyEn <= 1'b1;
              dlyCnt   <= '0;
              state    <= S_ONWAIT;
            end
            OP_OFF: if (powered) begin
              phase <= P_OFF1;
              state <= S_ISSUE;
            end
            OP_MIRR: begin
              mirrorReg <= cmdData[0];
              idx <= 5'(MIRR_IDX); lastIdx <= 5'(MIRR_IDX);
              if (powered) state <= S_ISSUE;
            end
            OP_MODE: if (cmdData[9:3] == '0) begin
              modeReg <= cmdData[2:0];
              idx <= '0; lastIdx <= '0;
              if (powered) state <= S_ISSUE;
            end
            OP_GAMMA: if (cmdIdx < 4'(GAMMA_N)) begin
              gammaReg[cmdIdx] <= cmdData;
              idx <= 5'(GHI_IDX); lastIdx <= 5'(LIST_LAST);
              if (powered) state <= S_ISSUE;
            end
            default: ;
          endcase
        end
        S_ONWAIT: begin
          dlyCnt <= dlyCnt + 1'b1;
          if (dlyCnt == DLY_W'(T_ON_CYC - 1)) begin
            panelRst <= 1'b0;
            powered  <= 1'b1;
            idx      <= '0;
            lastIdx  <= 5'(LIST_LAST);
            state    <= S_ISSUE;
          end
        end
        S_ISSUE: if (txIdle) state <= S_WAITD;
        S_WAITD: if (txDone) begin
          case (phase)
            P_OFF1: begin
              panelRst <= 1'b1;
              dlyCnt   <= '0;
              state    <= S_OFFWAIT;
            end
            P_OFF2: begin
              supplyEn <= 1'b0;
              powered  <= 1'b0;
              state    <= S_IDLE;
            end
            default: if (idx == lastIdx) state <= S_IDLE;
                     else begin
                       idx   <= idx + 1'b1;
                       state <= S_ISSUE;
                     end
          endcase
        end
        default: begin
          dlyCnt <= dlyCnt + 1'b1;
          if (dlyCnt == DLY_W'(T_OFF_CYC - 1)) begin
            phase <= P_OFF2;
            state <= S_ISSUE;
          end
        end
      endcase
    end
  end

  // R3
  rst_needs_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    !panelRst |-> supplyEn);
  // R7
  supply_off_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyEn) |-> panelRst);
  // R11
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> ($stable(modeReg) && $stable(mirrorReg)));
  // R3
  tx_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |-> (busy && supplyEn));

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int T_ON_CYC  = 20000000,
  parameter int T_OFF_CYC = 6250000,
  parameter int HALF_CYC  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [3:0] cmdIdx,
  input  logic [9:0] cmdData,
  output logic       busy,
  output logic       supplyEn,
  output logic       panelRst,
  output logic       spiSclk,
  output logic       spiCsN,
  output logic       spiMosi
);

  txStrobe_t strobe;
  logic      txIdle;
  logic      txDone;

  panel_seq_ctrl #(.T_ON_CYC(T_ON_CYC), .T_OFF_CYC(T_OFF_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdData(cmdData), .txIdle(txIdle), .txDone(txDone), .strobe(strobe),
    .busy(busy), .supplyEn(supplyEn), .panelRst(panelRst)
  );

  panel_spi_tx #(.HALF_CYC(HALF_CYC)) tx_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txIdle(txIdle), .txDone(txDone),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi)
  );

endmodule

// File: tb/panel_seq_top_tb_top.sv
module panel_seq_top_tb_top;

  localparam int T_ON  = 40;
  localparam int T_OFF = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [3:0] cmdIdx = '0;
  logic [9:0] cmdData = '0;
  logic       busy, supplyEn, panelRst, spiSclk, spiCsN, spiMosi;

  int testsRun = 0;
  int testsFailed = 0;

  // model of shadow state
  logic [2:0] mMode = 3'd7;
  logic       mMirror = 1'b0;
  logic [9:0] mGamma [12] = '{10'd105, 10'd315, 10'd381, 10'd431, 10'd490, 10'd537,
                              10'd579, 10'd686, 10'd780, 10'd837, 10'd880, 10'd1023};

  // expected item: {supplyEn, panelRst, word}
  logic [17:0] expQ [$];

  always #4 clk = ~clk;

  panel_seq_top #(.T_ON_CYC(T_ON), .T_OFF_CYC(T_OFF), .HALF_CYC(2)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdIdx(cmdIdx),
    .cmdData(cmdData), .busy(busy), .supplyEn(supplyEn), .panelRst(panelRst),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w(input logic [5:0] a, input logic [7:0] d);
    return {a, 2'b01, d}; // R1 layout
  endfunction

  task automatic pushW(input logic s, input logic r, input logic [15:0] word);
    expQ.push_back({s, r, word});
  endtask

  task automatic pushGamma();  // R5
    for (int g = 0; g < 3; g++)
      pushW(1, 0, w(6'h11 + 6'(g), {mGamma[4*g][9:8], mGamma[4*g+1][9:8],
                                     mGamma[4*g+2][9:8], mGamma[4*g+3][9:8]}));
    for (int i = 0; i < 12; i++) pushW(1, 0, w(6'h14 + 6'(i), mGamma[i][7:0]));
  endtask

  task automatic pushPowerOn();  // R3, R4
    pushW(1, 0, w(6'h02, {5'b00001, mMode}));
    pushW(1, 0, w(6'h03, 8'hDF));
    pushW(1, 0, w(6'h20, 8'hF0));
    pushW(1, 0, w(6'h21, 8'hF0));
    pushW(1, 0, w(6'h04, mMirror ? 8'h15 : 8'h17));
    pushGamma();
  endtask

  task automatic cmd(input logic [2:0] op, input logic [3:0] ix, input logic [9:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdIdx = ix; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0; cmdIdx = '0; cmdData = '0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(req, 32'(expQ.size()), 32'd0);
  endtask

  // monitor: decode serial words and compare against the queue
  logic [15:0] rxWord = '0;
  int          rxBits = 0;
  logic        prevSclk = 1'b0, prevCs = 1'b1, prevSup = 1'b0, prevRst = 1'b1;
  int          onCnt = 0, offCnt = 0;
  logic        onArm = 1'b0, offArm = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      onCnt++; offCnt++;
      if (supplyEn && !prevSup) begin onCnt = 0; onArm = 1'b1; end
      if (panelRst && !prevRst) begin offCnt = 0; offArm = 1'b1; end
      if (!spiCsN && prevCs) begin
        rxBits = 0;
        if (onArm) begin  // R3 settle delay before first word
          check("R3 settle", 32'(onCnt >= T_ON), 32'd1);
          onArm = 1'b0;
        end
        if (offArm) begin // R7 wait before final standby word
          check("R7 wait", 32'(offCnt >= T_OFF), 32'd1);
          offArm = 1'b0;
        end
      end
      if (spiSclk && !prevSclk && !spiCsN) begin
        rxWord = {rxWord[14:0], spiMosi};  // R2 MSB first
        rxBits++;
      end
      if (spiCsN && !prevCs) begin
        check("R2 clocks per word", 32'(rxBits), 32'd16);
        if (expQ.size() == 0) begin
          check("R8/R10 unexpected word", {14'b0, supplyEn, panelRst, rxWord}, 32'hFFFF_FFFF);
        end else begin
          logic [17:0] e;
          e = expQ.pop_front();
          check("R1/R3/R7 word", {14'b0, supplyEn, panelRst, rxWord}, {14'b0, e});
        end
      end
      prevSclk = spiSclk; prevCs = spiCsN; prevSup = supplyEn; prevRst = panelRst;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 supplyEn", 32'(supplyEn), 0);
    check("R6 panelRst", 32'(panelRst), 1);
    check("R6 busy", 32'(busy), 0);
    check("R6 spiCsN", 32'(spiCsN), 1);
    check("R6 spiSclk", 32'(spiSclk), 0);

    // R9 rejected mode while off; R10 shadow updates while off
    cmd(3'd4, 0, 10'd9);
    cmd(3'd3, 0, 10'd1); mMirror = 1'b1;
    cmd(3'd5, 4'd2, 10'h2C5); mGamma[2] = 10'h2C5;
    cmd(3'd5, 4'd12, 10'h3AA);  // R12 out-of-range index ignored
    cmd(3'd7, 0, 10'd0);        // R12 unused opcode
    repeat (100) @(negedge clk);
    check("R10 no traffic while off", 32'(supplyEn), 0);

    // R3 power up with default mode 7 (R6) and stored mirror/gamma
    pushPowerOn();
    cmd(3'd1, 0, 0);
    waitIdle();
    drained("R3 power-up script");
    check("R3 supplyEn", 32'(supplyEn), 1);
    check("R3 panelRst", 32'(panelRst), 0);

    // R8 redundant power up
    cmd(3'd1, 0, 0);
    check("R8 busy on redundant", 32'(busy), 0);
    repeat (100) @(negedge clk);

    // R9 rejected and accepted mode while powered
    cmd(3'd4, 0, 10'd8);
    check("R9 reject busy", 32'(busy), 0);
    repeat (100) @(negedge clk);
    mMode = 3'd3;
    pushW(1, 0, w(6'h02, 8'h0B));
    cmd(3'd4, 0, 10'd3);
    waitIdle();
    drained("R9 mode word");

    // R4/R10 mirror off while powered
    mMirror = 1'b0;
    pushW(1, 0, w(6'h04, 8'h17));
    cmd(3'd3, 0, 10'd0);
    waitIdle();
    drained("R4 mirror word");

    // R5/R10 gamma update while powered; R11 mirror dropped while busy
    mGamma[11] = 10'h155;
    pushGamma();
    cmd(3'd5, 4'd11, 10'h155);
    repeat (5) @(negedge clk);
    cmd(3'd3, 0, 10'd1);
    waitIdle();
    drained("R5 gamma rewrite");

    // R7 power down
    pushW(1, 0, w(6'h03, 8'hD8));
    pushW(1, 1, w(6'h03, 8'hD0));
    cmd(3'd2, 0, 0);
    waitIdle();
    drained("R7 power-down script");
    check("R7 supplyEn", 32'(supplyEn), 0);
    check("R7 panelRst", 32'(panelRst), 1);

    // R8 redundant power down
    cmd(3'd2, 0, 0);
    check("R8 busy on redundant off", 32'(busy), 0);
    repeat (100) @(negedge clk);

    // power up again: R11 mirror remains off, mode 3 kept
    pushPowerOn();
    cmd(3'd1, 0, 0);
    waitIdle();
    drained("R11 second power-up");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule